// File: doc/BRIEF.md
# Card Reset Protocol Selector with Answer-to-Reset Transmitter

This block sits behind the reset and clock pins of a secure-memory card. After power-on it watches how long the card reset input is held low. A reset that is already high, or that rises too early, puts the card in the synchronous 2-wire mode. A reset that rises after a long enough low period puts it in the asynchronous character mode. Whichever mode is chosen stays fixed until the next power-on reset. In the asynchronous mode the block sends a programmable answer-to-reset of `ATR_BYTES` bytes on the shared I/O line. It can only pull that line low: a logic 1 is sent by releasing the line.

Each transmitted element lasts one elementary time unit (ETU). An ETU is F/D card-clock cycles. After power-on F/D is 372/1. The ETU generator uses a fractional accumulator, so the eight negotiated speeds give the exact average period even when F/D is not a whole number. An outside parameter-selection parser hands over the index of a new speed with a valid/ready handshake. `fd_ready` is high only in the asynchronous mode after the answer-to-reset has finished. While `fd_ready` is low, `fd_valid` and `fd_idx` have no effect, and a source may hold them steady until the transfer is taken. A transfer happens on a rising clock edge with `fd_valid` and `fd_ready` both high. On that edge the new F/D takes effect and the ETU phase restarts.

Top module: `card_proto_select`

## Requirements
- R1: While `por_n` is low, and after it rises for as long as `card_rst` stays low, `mode` reads 0 (undecided). In that state `io_drive_low`, `etu_tick`, `atr_done`, `fd_ready` and `sync_ready` are all 0.
- R2: `mode` becomes 1 (synchronous) on the first clock edge that samples `card_rst` high after fewer than `LOW_MIN` (default 400) low cycles. This includes the case where `card_rst` is high from power-on. The mode then stays 1 until `por_n` goes low, whatever `card_rst` does. In this mode the I/O line is never driven and no ETU tick is produced.
- R3: `sync_ready` rises exactly `SYNC_PULSES` (default 5) clock edges after the edge that selected the synchronous mode, and then stays high.
- R4: `mode` becomes 2 (asynchronous) on the first clock edge that samples `card_rst` high after at least `LOW_MIN` clock edges sampled it low.
- R5: Once `mode` is 2, later `card_rst` pulses of any length change neither the mode nor the finished transmission state until `por_n` goes low.
- R6: After the asynchronous mode is selected, `etu_tick` pulses once every 372 clock cycles until a new speed is accepted.
- R7: Each answer-to-reset byte is sent as 12 ETUs in this order: a 0 start element, 8 data bits least significant bit first, an even-parity bit (the XOR of the data), then two guard ETUs at 1. Byte 0 is `atr_word[7:0]` and goes first. Each element begins on the clock edge after an `etu_tick` pulse.
- R8: `io_drive_low` is high only while an element of value 0 is being sent. The line is released in the undecided and synchronous modes, before the first ETU and after the transmission.
- R9: `atr_done` rises on the edge after the tick that ends the last guard ETU of the final byte, and it stays high.
- R10: `fd_ready` equals "mode is 2 and `atr_done` is 1". An offered index has no effect while `fd_ready` is low.
- R11: An accepted `fd_idx` selects F/D from this list: 0=372/1, 1=372/2, 2=372/4, 3=372/8, 4=372/12, 5=372/16, 6=512/8, 7=512/16. Any N consecutive tick intervals then add up to N·F/D clocks whenever that product is a whole number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| por_n | input | 1 | Power-on reset, active low |
| card_rst | input | 1 | Card reset pin level (already synchronised) |
| atr_word | input | 8*ATR_BYTES | Answer-to-reset contents, byte 0 in bits 7:0 |
| fd_valid | input | 1 | Negotiated speed index offered |
| fd_idx | input | 3 | Negotiated speed index |
| fd_ready | output | 1 | Speed index can be accepted |
| mode | output | 2 | 0 undecided, 1 synchronous, 2 asynchronous |
| sync_ready | output | 1 | Synchronous start-up clocks have been counted |
| io_drive_low | output | 1 | Pull the shared I/O line low |
| etu_tick | output | 1 | One-cycle pulse at the end of each ETU |
| atr_done | output | 1 | Answer-to-reset has been sent |

## Verification
The bound checker checks the following on every cycle:
- a chosen mode never changes;
- the I/O line is pulled only in the asynchronous mode before the transmission ends;
- `atr_done` and `sync_ready` never fall, and `sync_ready` appears only in the synchronous mode;
- ETU ticks occur only in the asynchronous mode;
- `fd_ready` implies a finished transmission.

Only the bench's scenarios can show the rest:
- the reset-width threshold that picks the mode;
- the exact element order and parity of every byte;
- the count of five start-up clocks;
- the tick spacing for each of the eight speeds.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int F_W      = 10;
  localparam int D_W      = 5;
  localparam int FD_IDX_W = 3;

  typedef enum logic [1:0] {
    MODE_WAIT  = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_ASYNC = 2'd2
  } mode_e;

  typedef struct packed {
    logic [F_W-1:0] f;
    logic [D_W-1:0] d;
  } fd_t;

  // Clock-rate / divisor pair for each negotiated speed index.
  function automatic fd_t fd_decode(input logic [FD_IDX_W-1:0] idx);
    fd_t r;
    r.f = 10'd372;
    r.d = 5'd1;
    case (idx)
      3'd0: r.d = 5'd1;
      3'd1: r.d = 5'd2;
      3'd2: r.d = 5'd4;
      3'd3: r.d = 5'd8;
      3'd4: r.d = 5'd12;
      3'd5: r.d = 5'd16;
      3'd6: begin r.f = 10'd512; r.d = 5'd8;  end
      default: begin r.f = 10'd512; r.d = 5'd16; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cps_mode_detect.sv
module cps_mode_detect
  import cps_pkg::*;
#(
  parameter int LOW_MIN     = 400,
  parameter int SYNC_PULSES = 5
) (
  input  logic  clk,
  input  logic  por_n,
  input  logic  card_rst,
  output mode_e mode,
  output logic  sync_ready
);
  localparam int CW = $clog2(LOW_MIN + 1);
  localparam int SW = $clog2(SYNC_PULSES + 1);

  logic [CW-1:0] low_cnt;
  logic [SW-1:0] sync_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode     <= MODE_WAIT;
      low_cnt  <= '0;
      sync_cnt <= '0;
    end else begin
      case (mode)
        MODE_WAIT: begin
          if (card_rst)
            mode <= (low_cnt >= CW'(LOW_MIN)) ? MODE_ASYNC : MODE_SYNC;
          else if (low_cnt != CW'(LOW_MIN))
            low_cnt <= low_cnt + 1'b1;
        end
        MODE_SYNC: begin
          if (sync_cnt != SW'(SYNC_PULSES))
            sync_cnt <= sync_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sync_ready = (mode == MODE_SYNC) && (sync_cnt == SW'(SYNC_PULSES));
endmodule

// File: rtl/cps_etu_gen.sv
module cps_etu_gen
  import cps_pkg::*;
#(
  parameter int DEF_IDX = 0
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                en,
  input  logic                fd_load,
  input  logic [FD_IDX_W-1:0] fd_idx,
  output logic                tick
);
  localparam int ACC_W = F_W + 1;

  fd_t             fd_q;
  logic [ACC_W-1:0] acc, acc_nxt;
  logic             hit;

  // Fractional accumulator: add D per clock, emit a tick each time F is crossed.
  assign acc_nxt = acc + ACC_W'(fd_q.d);
  assign hit     = acc_nxt >= ACC_W'(fd_q.f);
  assign tick    = en && !fd_load && hit;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      acc  <= '0;
      fd_q <= fd_decode(FD_IDX_W'(DEF_IDX));
    end else if (fd_load) begin
      acc  <= '0;
      fd_q <= fd_decode(fd_idx);
    end else if (en) begin
      acc <= hit ? (acc_nxt - ACC_W'(fd_q.f)) : acc_nxt;
    end
  end
endmodule

// File: rtl/cps_atr_tx.sv
module cps_atr_tx #(
  parameter int N_BYTES = 8,
  parameter int GUARD   = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 en,
  input  logic                 tick,
  input  logic [N_BYTES*8-1:0] atr,
  output logic                 io_low,
  output logic                 done
);
  localparam int CHAR_ETUS = 10 + GUARD;
  localparam int IW        = $clog2(CHAR_ETUS);
  localparam int BW        = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_DONE} tx_e;

  tx_e           st;
  logic [IW-1:0] pos;
  logic [BW-1:0] byte_idx;
  logic [7:0]    cur_byte;
  logic          bit_val;

  assign cur_byte = atr[{byte_idx, 3'b000} +: 8];

  always_comb begin
    if (pos == '0)
      bit_val = 1'b0;
    else if (pos <= IW'(8))
      bit_val = cur_byte[3'(pos - IW'(1))];
    else if (pos == IW'(9))
      bit_val = ^cur_byte;
    else
      bit_val = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= TX_IDLE;
      pos      <= '0;
      byte_idx <= '0;
    end else begin
      case (st)
        TX_IDLE: if (en && tick) begin
          st       <= TX_SEND;
          pos      <= '0;
          byte_idx <= '0;
        end
        TX_SEND: if (tick) begin
          if (pos == IW'(CHAR_ETUS - 1)) begin
            pos <= '0;
            if (byte_idx == BW'(N_BYTES - 1)) st <= TX_DONE;
            else byte_idx <= byte_idx + 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign io_low = (st == TX_SEND) && !bit_val;
  assign done   = (st == TX_DONE);
endmodule

// File: rtl/card_proto_select.sv
module card_proto_select
  import cps_pkg::*;
#(
  parameter int LOW_MIN     = 400,
  parameter int SYNC_PULSES = 5,
  parameter int ATR_BYTES   = 8,
  parameter int GUARD_ETUS  = 2,
  parameter int DEF_FD_IDX  = 0,
  localparam int ATR_W      = ATR_BYTES * 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             card_rst,
  input  logic [ATR_W-1:0] atr_word,
  input  logic             fd_valid,
  input  logic [2:0]       fd_idx,
  output logic             fd_ready,
  output logic [1:0]       mode,
  output logic             sync_ready,
  output logic             io_drive_low,
  output logic             etu_tick,
  output logic             atr_done
);
  mode_e mode_q;
  logic  is_async;
  logic  fd_take;

  cps_mode_detect #(.LOW_MIN(LOW_MIN), .SYNC_PULSES(SYNC_PULSES)) u_mode (
    .clk(clk), .por_n(por_n), .card_rst(card_rst),
    .mode(mode_q), .sync_ready(sync_ready)
  );

  assign is_async = (mode_q == MODE_ASYNC);
  assign fd_ready = is_async && atr_done;
  assign fd_take  = fd_valid && fd_ready;

  cps_etu_gen #(.DEF_IDX(DEF_FD_IDX)) u_etu (
    .clk(clk), .por_n(por_n), .en(is_async),
    .fd_load(fd_take), .fd_idx(fd_idx), .tick(etu_tick)
  );

  cps_atr_tx #(.N_BYTES(ATR_BYTES), .GUARD(GUARD_ETUS)) u_atr (
    .clk(clk), .por_n(por_n), .en(is_async), .tick(etu_tick),
    .atr(atr_word), .io_low(io_drive_low), .done(atr_done)
  );

  assign mode = mode_q;
endmodule

// File: rtl/card_proto_select_chk.sv
module card_proto_select_chk
  import cps_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic [1:0] mode,
  input logic       sync_ready,
  input logic       io_drive_low,
  input logic       etu_tick,
  input logic       atr_done,
  input logic       fd_ready
);
  // R2
  sync_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_SYNC) |=> (mode == MODE_SYNC));
  // R5
  async_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_ASYNC) |=> (mode == MODE_ASYNC));
  // R3
  sync_ready_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    sync_ready |-> (mode == MODE_SYNC));
  // R3
  sync_ready_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    sync_ready |=> sync_ready);
  // R8
  drive_window_chk: assert property (@(posedge clk) disable iff (!por_n)
    io_drive_low |-> ((mode == MODE_ASYNC) && !atr_done));
  // R6
  tick_async_chk: assert property (@(posedge clk) disable iff (!por_n)
    etu_tick |-> (mode == MODE_ASYNC));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    atr_done |=> atr_done);
  // R10
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!por_n)
    fd_ready |-> atr_done);
endmodule

bind card_proto_select card_proto_select_chk u_chk (
  .clk(clk), .por_n(por_n), .mode(mode), .sync_ready(sync_ready),
  .io_drive_low(io_drive_low), .etu_tick(etu_tick),
  .atr_done(atr_done), .fd_ready(fd_ready)
);

// File: tb/sim_card_proto_select.sv
`timescale 1ns/1ps
module sim_card_proto_select;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        card_rst = 1'b1;
  logic [63:0] atr_word = 64'h3B7E_00FF_A581_C396;
  logic        fd_valid = 1'b0;
  logic [2:0]  fd_idx = 3'd0;
  logic        fd_ready, sync_ready, io_drive_low, etu_tick, atr_done;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  card_proto_select u0 (
    .clk(clk), .por_n(por_n), .card_rst(card_rst), .atr_word(atr_word),
    .fd_valid(fd_valid), .fd_idx(fd_idx), .fd_ready(fd_ready), .mode(mode),
    .sync_ready(sync_ready), .io_drive_low(io_drive_low),
    .etu_tick(etu_tick), .atr_done(atr_done)
  );

  // {speed index, intervals summed, expected clocks}
  localparam logic [18:0] SPEED_TBL [8] = '{
    {3'd0, 4'd1, 12'd372}, {3'd1, 4'd1, 12'd186},
    {3'd2, 4'd1, 12'd93},  {3'd3, 4'd2, 12'd93},
    {3'd4, 4'd1, 12'd31},  {3'd5, 4'd4, 12'd93},
    {3'd6, 4'd1, 12'd64},  {3'd7, 4'd1, 12'd32}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic power_cycle(input logic rst_lvl);
    @(negedge clk);
    por_n = 1'b0;
    card_rst = rst_lvl;
    fd_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", 64'(mode), 64'd0);
    chk("R1 outputs", {59'd0, io_drive_low, etu_tick, atr_done, fd_ready, sync_ready}, 64'd0);
    por_n = 1'b1;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!etu_tick);
  endtask

  task automatic measure(input int n, output int total);
    total = 0;
    wait_tick();
    for (int k = 0; k < n; k++) begin
      do begin @(negedge clk); total++; end while (!etu_tick);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    int total;
    logic [11:0] got, exp_c;
    logic [7:0]  b;

    // Scenario A: reset high from power-on -> synchronous
    power_cycle(1'b1);
    @(negedge clk);
    chk("R2 reset-high selects sync", 64'(mode), 64'd1);
    repeat (4) @(negedge clk);
    chk("R3 not ready after 4 clocks", 64'(sync_ready), 64'd0);
    @(negedge clk);
    chk("R3 ready after 5 clocks", 64'(sync_ready), 64'd1);
    card_rst = 1'b0;
    bad = 0;
    for (int i = 0; i < 450; i++) begin
      @(negedge clk);
      if (io_drive_low || etu_tick) bad++;
    end
    card_rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 sync stays locked", 64'(mode), 64'd1);
    chk("R8 line idle in sync mode", 64'(bad), 64'd0);

    // Scenario B: short low reset -> synchronous
    power_cycle(1'b0);
    repeat (390) @(negedge clk);
    card_rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 short low selects sync", 64'(mode), 64'd1);

    // Scenario C: long low reset -> asynchronous
    power_cycle(1'b0);
    repeat (100) @(negedge clk);
    chk("R1 undecided while reset low", 64'(mode), 64'd0);
    chk("R1 no sync_ready while undecided", 64'(sync_ready), 64'd0);
    repeat (350) @(negedge clk);
    card_rst = 1'b1;
    @(negedge clk);
    chk("R4 long low selects async", 64'(mode), 64'd2);
    chk("R8 released before first ETU", 64'(io_drive_low), 64'd0);
    fd_valid = 1'b1;
    fd_idx = 3'd7;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (fd_ready) bad++;
    end
    fd_valid = 1'b0;
    chk("R10 not ready during ATR", 64'(bad), 64'd0);

    for (int bi = 0; bi < 8; bi++) begin
      b = atr_word[bi*8 +: 8];
      exp_c = {2'b11, ^b, b, 1'b0};
      got = '0;
      for (int e = 0; e < 12; e++) begin
        wait_tick();
        repeat (5) @(negedge clk);
        got[e] = !io_drive_low;
        if (bi == 7 && e == 11) chk("R9 not done in last guard", 64'(atr_done), 64'd0);
      end
      chk("R7 ATR character", 64'(got), 64'(exp_c));
    end
    wait_tick();
    @(negedge clk);
    chk("R9 done after last guard", 64'(atr_done), 64'd1);
    chk("R8 released after ATR", 64'(io_drive_low), 64'd0);
    chk("R10 ready after ATR", 64'(fd_ready), 64'd1);
    measure(1, total);
    chk("R6 default ETU / R10 refused index ignored", 64'(total), 64'd372);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      fd_idx = SPEED_TBL[i][18:16];
      fd_valid = 1'b1;
      @(negedge clk);
      fd_valid = 1'b0;
      measure(int'(SPEED_TBL[i][15:12]), total);
      chk($sformatf("R11 speed index %0d", i), 64'(total), 64'(SPEED_TBL[i][11:0]));
    end

    card_rst = 1'b0;
    repeat (500) @(negedge clk);
    card_rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 async locked", 64'(mode), 64'd2);
    chk("R5 done kept", 64'(atr_done), 64'd1);
    chk("R8 released after reset pulse", 64'(io_drive_low), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule